// File: doc/BRIEF.md
# Sparse Synapse-List Recurrent Network Stepper

This block advances a discrete-time recurrent network by exactly one step for each request. The network is not held as a dense weight matrix. It is held as a fixed-length list of synapse entries. Each entry names a source (a neuron, or a reserved constant-one source that supplies a bias), a signed weight and a destination neuron. For each step the block reads the list one entry per cycle and adds each weighted source activation into a sum for the destination. It then makes one pass over the configured neurons, saturates each sum into the unit interval and writes it to a second state bank. The two banks change roles when the pass ends, so every new value depends only on the previous step.

The host writes synapse entries and initial activations while the block is idle. It sets the active neuron count, pulses a start request and waits for the one-cycle completion pulse. It then reads any neuron's activation through a combinational readout port. The host can rewrite a weight between steps, which also lets it disable a neuron by writing zero to all of that neuron's incoming and outgoing weights.

Top module: `synlist_stepper`

## Requirements
- R1: After reset, `busy` and `step_done` are 0, every synapse entry has weight zero, and every neuron activation reads 0.
- R2: Activations are 16-bit unsigned fractions where 0x8000 means 1.0. A preload value above 0x8000 is stored as 0x8000, and a value at or below 0x8000 is stored unchanged.
- R3: A step sets each active neuron to the sum, over its valid incoming entries, of floor(activation × weight / 256), where the weight is a signed 16-bit Q8.8 value (0x0100 = 1.0). The sum is then saturated: a negative sum gives 0, a sum above 0x8000 gives 0x8000, and any other sum passes unchanged.
- R4: A source code equal to the neuron capacity (64 by default) is the bias source, which always contributes with activation 0x8000.
- R5: All neurons update together. Every term in step t+1 uses activations from the end of step t, even when a neuron's own new value has already been written.
- R6: An entry is skipped when its source is not the bias code and is not below the active neuron count, or when its destination is not below the active neuron count.
- R7: When `step_start` is sampled, `step_done` rises exactly TRIPLES + N clock edges later, where N is the active neuron count sampled with the start. `step_done` is high for one cycle, `busy` is high from the edge after the start until that edge, and the activations change only then.
- R8: While `busy` is high, synapse writes, preload writes and `step_start` have no effect.
- R9: The readout returns 0 for any address not below `cfg_neurons`.
- R10: A synapse weight rewritten between steps takes effect at the next step. Zero weights remove that entry's contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_neurons | input | 7 | Active neuron count, 0..64 |
| tl_we | input | 1 | Synapse entry write strobe |
| tl_addr | input | 8 | Synapse entry index |
| tl_src | input | 7 | Source neuron, or 64 for the bias source |
| tl_wgt | input | 16 | Signed Q8.8 weight |
| tl_dst | input | 6 | Destination neuron |
| sp_we | input | 1 | Activation preload strobe |
| sp_addr | input | 6 | Neuron to preload |
| sp_data | input | 16 | Preload activation |
| step_start | input | 1 | Request one network step |
| busy | output | 1 | Step in progress |
| step_done | output | 1 | One-cycle pulse when new activations are visible |
| rd_addr | input | 6 | Readout neuron |
| rd_data | output | 16 | Current activation of `rd_addr` |

## Verification
A corrupted accumulator or a wrongly decoded entry shows up as a wrong activation on `rd_data` right after the next `step_done`. A fault in bank selection shows up the same way, or it leaves the activations unchanged or shows the previous step's values. Swapped-neuron steps expose any term that reads a freshly committed value instead of the prior one. A sequencing fault moves the `step_done` edge away from TRIPLES + N, and the bench measures that count on every step. Writes made while busy are checked by reading the outcome of the current step and of the following step.

// File: rtl/synlist_pkg.sv
package synlist_pkg;

  localparam int ACT_W = 16;
  localparam int WGT_W = 16;
  localparam int ACC_W = 32;
  localparam logic [ACT_W-1:0] ACT_ONE = 16'h8000;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WALK  = 2'd1,
    SEQ_CLAMP = 2'd2
  } seq_state_e;

  // weighted contribution of one entry, scaled back to activation units
  function automatic logic signed [ACC_W-1:0] syn_term(
    input logic [ACT_W-1:0]        act,
    input logic signed [WGT_W-1:0] wgt
  );
    logic signed [ACT_W+WGT_W:0] prod;
    logic signed [ACT_W+WGT_W:0] shd;
    prod = $signed({1'b0, act}) * wgt;
    shd  = prod >>> 8;
    return shd[ACC_W-1:0];
  endfunction

  // saturate a sum into the unit interval
  function automatic logic [ACT_W-1:0] sat_unit(input logic signed [ACC_W-1:0] s);
    if (s < 0)
      return '0;
    else if (s > $signed({{(ACC_W-ACT_W){1'b0}}, ACT_ONE}))
      return ACT_ONE;
    else
      return s[ACT_W-1:0];
  endfunction

  function automatic logic [ACT_W-1:0] sat_preload(input logic [ACT_W-1:0] v);
    return (v > ACT_ONE) ? ACT_ONE : v;
  endfunction

endpackage

// File: rtl/synlist_store.sv
module synlist_store #(
  parameter int TRIPLES = 256,
  parameter int NIDX_W  = 6,
  parameter int WGT_W   = 16,
  localparam int TIDX_W = $clog2(TRIPLES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [TIDX_W-1:0]       wr_addr,
  input  logic [NIDX_W:0]         wr_src,
  input  logic signed [WGT_W-1:0] wr_wgt,
  input  logic [NIDX_W-1:0]       wr_dst,
  input  logic [TIDX_W-1:0]       rd_idx,
  output logic [NIDX_W:0]         rd_src,
  output logic signed [WGT_W-1:0] rd_wgt,
  output logic [NIDX_W-1:0]       rd_dst
);

  logic [NIDX_W:0]         src_mem [TRIPLES];
  logic signed [WGT_W-1:0] wgt_mem [TRIPLES];
  logic [NIDX_W-1:0]       dst_mem [TRIPLES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TRIPLES; i++) begin
        src_mem[i] <= '0;
        wgt_mem[i] <= '0;
        dst_mem[i] <= '0;
      end
    end else if (wr_en) begin
      src_mem[wr_addr] <= wr_src;
      wgt_mem[wr_addr] <= wr_wgt;
      dst_mem[wr_addr] <= wr_dst;
    end
  end

  assign rd_src = src_mem[rd_idx];
  assign rd_wgt = wgt_mem[rd_idx];
  assign rd_dst = dst_mem[rd_idx];

endmodule

// File: rtl/synlist_banks.sv
module synlist_banks #(
  parameter int NEURONS = 64,
  parameter int NIDX_W  = 6,
  parameter int ACT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_en,
  input  logic [NIDX_W-1:0] pre_addr,
  input  logic [ACT_W-1:0]  pre_data,
  input  logic [NIDX_W-1:0] src_idx,
  output logic [ACT_W-1:0]  src_act,
  input  logic              cmt_en,
  input  logic [NIDX_W-1:0] cmt_addr,
  input  logic [ACT_W-1:0]  cmt_data,
  input  logic              swap,
  input  logic [NIDX_W-1:0] ro_addr,
  output logic [ACT_W-1:0]  ro_data,
  output logic              cur_sel
);

  logic [ACT_W-1:0] bank0 [NEURONS];
  logic [ACT_W-1:0] bank1 [NEURONS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_sel <= 1'b0;
      for (int i = 0; i < NEURONS; i++) begin
        bank0[i] <= '0;
        bank1[i] <= '0;
      end
    end else begin
      if (pre_en) begin
        if (cur_sel) bank1[pre_addr] <= pre_data;
        else         bank0[pre_addr] <= pre_data;
      end
      if (cmt_en) begin
        if (cur_sel) bank0[cmt_addr] <= cmt_data;
        else         bank1[cmt_addr] <= cmt_data;
      end
      if (swap) cur_sel <= ~cur_sel;
    end
  end

  assign src_act = cur_sel ? bank1[src_idx] : bank0[src_idx];
  assign ro_data = cur_sel ? bank1[ro_addr] : bank0[ro_addr];

endmodule

// File: rtl/synlist_accum.sv
module synlist_accum #(
  parameter int NEURONS = 64,
  parameter int NIDX_W  = 6,
  parameter int ACC_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    add_en,
  input  logic [NIDX_W-1:0]       add_idx,
  input  logic signed [ACC_W-1:0] add_val,
  input  logic [NIDX_W-1:0]       rd_idx,
  output logic signed [ACC_W-1:0] rd_val
);

  logic signed [ACC_W-1:0] acc [NEURONS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NEURONS; i++) acc[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NEURONS; i++) acc[i] <= '0;
    end else if (add_en) begin
      acc[add_idx] <= acc[add_idx] + add_val;
    end
  end

  assign rd_val = acc[rd_idx];

endmodule

// File: rtl/synlist_seq.sv
module synlist_seq #(
  parameter int TRIPLES = 256,
  parameter int NIDX_W  = 6,
  localparam int TIDX_W = $clog2(TRIPLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NIDX_W:0]   n_cfg,
  output logic              busy,
  output logic              clr,
  output logic              walk_en,
  output logic [TIDX_W-1:0] walk_idx,
  output logic              clamp_en,
  output logic [NIDX_W-1:0] clamp_idx,
  output logic [NIDX_W:0]   n_act,
  output logic              swap,
  output logic              done
);
  import synlist_pkg::*;

  localparam logic [TIDX_W-1:0] LAST_T = TIDX_W'(TRIPLES - 1);

  seq_state_e state;
  logic walk_last, clamp_last;

  assign busy       = (state != SEQ_IDLE);
  assign clr        = (state == SEQ_IDLE) && start;
  assign walk_en    = (state == SEQ_WALK);
  assign clamp_en   = (state == SEQ_CLAMP);
  assign walk_last  = walk_en && (walk_idx == LAST_T);
  assign clamp_last = clamp_en && ({1'b0, clamp_idx} == n_act - 1'b1);
  assign swap       = (walk_last && (n_act == '0)) || clamp_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      walk_idx  <= '0;
      clamp_idx <= '0;
      n_act     <= '0;
      done      <= 1'b0;
    end else begin
      done <= swap;
      unique case (state)
        SEQ_IDLE: if (start) begin
          state    <= SEQ_WALK;
          walk_idx <= '0;
          n_act    <= n_cfg;
        end
        SEQ_WALK: begin
          walk_idx <= walk_idx + 1'b1;
          if (walk_last) begin
            clamp_idx <= '0;
            state     <= (n_act == '0) ? SEQ_IDLE : SEQ_CLAMP;
          end
        end
        SEQ_CLAMP: begin
          clamp_idx <= clamp_idx + 1'b1;
          if (clamp_last) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/synlist_stepper.sv
module synlist_stepper #(
  parameter int NEURONS = 64,
  parameter int TRIPLES = 256,
  parameter int ACT_W   = synlist_pkg::ACT_W,
  parameter int WGT_W   = synlist_pkg::WGT_W,
  parameter int ACC_W   = synlist_pkg::ACC_W,
  localparam int NIDX_W = $clog2(NEURONS),
  localparam int TIDX_W = $clog2(TRIPLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIDX_W:0]   cfg_neurons,
  input  logic              tl_we,
  input  logic [TIDX_W-1:0] tl_addr,
  input  logic [NIDX_W:0]   tl_src,
  input  logic [WGT_W-1:0]  tl_wgt,
  input  logic [NIDX_W-1:0] tl_dst,
  input  logic              sp_we,
  input  logic [NIDX_W-1:0] sp_addr,
  input  logic [ACT_W-1:0]  sp_data,
  input  logic              step_start,
  output logic              busy,
  output logic              step_done,
  input  logic [NIDX_W-1:0] rd_addr,
  output logic [ACT_W-1:0]  rd_data
);
  import synlist_pkg::*;

  localparam logic [NIDX_W:0] BIAS_CODE = (NIDX_W+1)'(NEURONS);

  // named internal events for the checker
  logic                    walk_en, clamp_en, clr, swap_evt;
  logic                    walk_fire, clamp_fire, cur_sel;
  logic [TIDX_W-1:0]       walk_idx;
  logic [NIDX_W-1:0]       clamp_idx;
  logic [NIDX_W:0]         n_act;
  logic [NIDX_W:0]         e_src;
  logic signed [WGT_W-1:0] e_wgt;
  logic [NIDX_W-1:0]       e_dst;
  logic [ACT_W-1:0]        src_act, e_act, cmt_data, ro_data;
  logic signed [ACC_W-1:0] add_val, sum_val;
  logic                    is_bias, src_ok, dst_ok;

  synlist_seq #(.TRIPLES(TRIPLES), .NIDX_W(NIDX_W)) u_seq (
    .clk, .rst_n, .start(step_start), .n_cfg(cfg_neurons), .busy,
    .clr, .walk_en, .walk_idx, .clamp_en, .clamp_idx, .n_act,
    .swap(swap_evt), .done(step_done)
  );

  synlist_store #(.TRIPLES(TRIPLES), .NIDX_W(NIDX_W), .WGT_W(WGT_W)) u_store (
    .clk, .rst_n, .wr_en(tl_we && !busy), .wr_addr(tl_addr), .wr_src(tl_src),
    .wr_wgt($signed(tl_wgt)), .wr_dst(tl_dst), .rd_idx(walk_idx),
    .rd_src(e_src), .rd_wgt(e_wgt), .rd_dst(e_dst)
  );

  assign is_bias   = (e_src == BIAS_CODE);
  assign src_ok    = is_bias || (e_src < n_act);
  assign dst_ok    = ({1'b0, e_dst} < n_act);
  assign walk_fire = walk_en && src_ok && dst_ok;
  assign e_act     = is_bias ? ACT_ONE : src_act;
  assign add_val   = syn_term(e_act, e_wgt);

  synlist_accum #(.NEURONS(NEURONS), .NIDX_W(NIDX_W), .ACC_W(ACC_W)) u_acc (
    .clk, .rst_n, .clr, .add_en(walk_fire), .add_idx(e_dst), .add_val,
    .rd_idx(clamp_idx), .rd_val(sum_val)
  );

  assign clamp_fire = clamp_en;
  assign cmt_data   = sat_unit(sum_val);

  synlist_banks #(.NEURONS(NEURONS), .NIDX_W(NIDX_W), .ACT_W(ACT_W)) u_banks (
    .clk, .rst_n, .pre_en(sp_we && !busy), .pre_addr(sp_addr),
    .pre_data(sat_preload(sp_data)), .src_idx(e_src[NIDX_W-1:0]), .src_act,
    .cmt_en(clamp_fire), .cmt_addr(clamp_idx), .cmt_data, .swap(swap_evt),
    .ro_addr(rd_addr), .ro_data, .cur_sel
  );

  assign rd_data = ({1'b0, rd_addr} < cfg_neurons) ? ro_data : '0;

endmodule

// File: rtl/synlist_stepper_chk.sv
module synlist_stepper_chk #(
  parameter int NIDX_W = 6,
  parameter int ACT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              step_done,
  input logic              walk_fire,
  input logic              clamp_fire,
  input logic              swap_evt,
  input logic              cur_sel,
  input logic [ACT_W-1:0]  cmt_data,
  input logic [NIDX_W:0]   cfg_neurons,
  input logic [NIDX_W-1:0] rd_addr,
  input logic [ACT_W-1:0]  rd_data
);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (!busy && $past(busy)));

  p_commit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_fire |-> (cmt_data <= 16'h8000));

  p_readout_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rd_addr} >= cfg_neurons) |-> (rd_data == '0));

  p_swap_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (cur_sel != $past(cur_sel)));

  p_sel_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_evt |=> $stable(cur_sel));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!walk_fire && !clamp_fire && !swap_evt));

endmodule

bind synlist_stepper synlist_stepper_chk #(.NIDX_W(NIDX_W), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .step_done(step_done),
  .walk_fire(walk_fire), .clamp_fire(clamp_fire), .swap_evt(swap_evt),
  .cur_sel(cur_sel), .cmt_data(cmt_data), .cfg_neurons(cfg_neurons),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_synlist_stepper.sv
`timescale 1ns/1ps
module tb_synlist_stepper;

  localparam int NN = 64;
  localparam int NT = 256;
  localparam int BIAS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_neurons = '0;
  logic        tl_we = 1'b0;
  logic [7:0]  tl_addr = '0;
  logic [6:0]  tl_src = '0;
  logic [15:0] tl_wgt = '0;
  logic [5:0]  tl_dst = '0;
  logic        sp_we = 1'b0;
  logic [5:0]  sp_addr = '0;
  logic [15:0] sp_data = '0;
  logic        step_start = 1'b0;
  logic        busy, step_done;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  synlist_stepper dut (.*);

  int checks = 0, errors = 0;
  int m_src [NT], m_wgt [NT], m_dst [NT];
  int m_st [NN];
  int n_cfg = 0;

  typedef struct { int addr; int val; string req; } exp_t;
  exp_t exp_q[$];
  int pending = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected readouts and compares against the port
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      begin
        exp_t e;
        e = exp_q.pop_front();
        @(negedge clk);
        rd_addr = 6'(e.addr);
        #1;
        chk(e.req, int'(rd_data), e.val);
        pending--;
      end
    end
  end

  task automatic expect_one(int a, int v, string req);
    exp_t e;
    e.addr = a; e.val = v; e.req = req;
    pending++;
    exp_q.push_back(e);
  endtask

  task automatic expect_all(string req);
    for (int n = 0; n < n_cfg; n++) expect_one(n, m_st[n], req);
    wait (pending == 0);
  endtask

  task automatic set_cfg(int n);
    @(negedge clk);
    cfg_neurons = 7'(n);
    n_cfg = n;
  endtask

  task automatic load_syn(int i, int s, int w, int d);
    @(negedge clk);
    tl_we = 1'b1; tl_addr = 8'(i); tl_src = 7'(s); tl_wgt = 16'(w); tl_dst = 6'(d);
    @(negedge clk);
    tl_we = 1'b0;
    m_src[i] = s; m_wgt[i] = w; m_dst[i] = d;
  endtask

  task automatic preload(int a, int v);
    @(negedge clk);
    sp_we = 1'b1; sp_addr = 6'(a); sp_data = 16'(v);
    @(negedge clk);
    sp_we = 1'b0;
    m_st[a] = (v > 32768) ? 32768 : v;
  endtask

  // floor(act*w/256) written with integer division
  function automatic int term(int act, int w);
    int p;
    p = act * w;
    if (p >= 0) return p / 256;
    return -(((-p) + 255) / 256);
  endfunction

  task automatic model_step();
    int sum [NN];
    int nxt [NN];
    for (int n = 0; n < NN; n++) sum[n] = 0;
    for (int t = 0; t < NT; t++) begin
      int act;
      bit ok;
      ok = 1;
      if (m_src[t] == BIAS) act = 32768;
      else if (m_src[t] < n_cfg) act = m_st[m_src[t]];
      else begin act = 0; ok = 0; end
      if (m_dst[t] >= n_cfg) ok = 0;
      if (ok) begin
        int w;
        w = (m_wgt[t] >= 32768) ? m_wgt[t] - 65536 : m_wgt[t];
        sum[m_dst[t]] += term(act, w);
      end
    end
    for (int n = 0; n < n_cfg; n++)
      nxt[n] = (sum[n] < 0) ? 0 : ((sum[n] > 32768) ? 32768 : sum[n]);
    for (int n = 0; n < n_cfg; n++) m_st[n] = nxt[n];
  endtask

  // runs one step, measures the done edge, optionally pokes inputs while busy
  task automatic do_step(bit intrude);
    int k;
    @(negedge clk);
    step_start = 1'b1;
    @(posedge clk);
    #1 step_start = 1'b0;
    k = 0;
    while (!step_done && k < 2000) begin
      @(posedge clk);
      #1;
      k++;
      if (k == 1) chk("R7 busy during step", int'(busy), 1);
      if (intrude && k == 3) begin
        tl_we = 1'b1; tl_addr = 8'd1; tl_src = 7'd64; tl_wgt = 16'h7fff; tl_dst = 6'd0;
        sp_we = 1'b1; sp_addr = 6'd1; sp_data = 16'h7777;
        step_start = 1'b1;
      end
      if (intrude && k == 4) begin
        tl_we = 1'b0; sp_we = 1'b0; step_start = 1'b0;
      end
    end
    chk("R7 done edge count", k, NT + n_cfg);
    chk("R7 busy low at done", int'(busy), 0);
    @(posedge clk);
    #1;
    chk("R7 done one cycle", int'(step_done), 0);
    model_step();
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin m_src[t] = 0; m_wgt[t] = 0; m_dst[t] = 0; end
    for (int n = 0; n < NN; n++) m_st[n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 step_done", int'(step_done), 0);
    set_cfg(4);
    expect_all("R1 reset activation");

    // R2 preload saturation and encoding
    preload(0, 16'hffff);
    expect_one(0, 32768, "R2 preload above one");
    preload(2, 16'h8000);
    expect_one(2, 32768, "R2 preload exactly one");
    wait (pending == 0);
    preload(0, 16'h4000);
    preload(1, 16'h2000);
    preload(2, 0);

    // R3/R4 weighted sum, saturation both ways, bias
    load_syn(0, 0, 16'h0100, 2);
    load_syn(1, 1, 16'h0200, 2);
    load_syn(2, BIAS, 16'h0080, 3);
    load_syn(3, 0, 16'hff00, 1);
    load_syn(4, BIAS, 16'h0100, 2);
    do_step(0);
    expect_one(2, 32768, "R3 high saturation");
    expect_one(1, 0, "R3 negative to zero");
    expect_one(3, 16'h4000, "R4 bias half");
    wait (pending == 0);
    expect_all("R3 weighted sums");

    // R5 synchronous update: swap two neurons twice
    for (int t = 0; t < 5; t++) load_syn(t, 0, 0, 0);
    preload(0, 16'h1000);
    preload(1, 16'h3000);
    load_syn(0, 0, 16'h0100, 1);
    load_syn(1, 1, 16'h0100, 0);
    do_step(0);
    expect_one(0, 16'h3000, "R5 swap first");
    expect_one(1, 16'h1000, "R5 swap first");
    wait (pending == 0);
    do_step(0);
    expect_all("R5 swap back");

    // R6 out-of-range entries skipped, R9 readout mask
    preload(5, 16'h8000);
    load_syn(2, 5, 16'h0100, 3);
    load_syn(3, 0, 16'h0100, 10);
    do_step(0);
    expect_one(3, 0, "R6 skipped entries");
    wait (pending == 0);
    expect_all("R6 state");
    @(negedge clk);
    rd_addr = 6'd5;
    #1 chk("R9 masked readout", int'(rd_data), 0);

    // R8 writes during busy ignored, now and in the following step
    do_step(1);
    expect_all("R8 ignored during busy");
    do_step(0);
    expect_all("R8 ignored next step");
    repeat (3) begin
      @(negedge clk);
      chk("R8 start ignored", int'(busy), 0);
    end

    // R10 runtime weight rewrite, zero disables
    preload(0, 16'h2000);
    preload(1, 16'h6000);
    load_syn(1, 1, 16'h0080, 0);
    do_step(0);
    expect_one(0, 16'h3000, "R10 rewritten weight");
    wait (pending == 0);
    load_syn(1, 1, 0, 0);
    load_syn(0, 0, 0, 1);
    do_step(0);
    expect_one(0, 0, "R10 zeroed inputs");
    expect_one(1, 0, "R10 zeroed inputs");
    wait (pending == 0);

    // R7 zero active neurons
    set_cfg(0);
    do_step(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule